// File: doc/BRIEF.md
# Row-Buffered Array Write Engine with Timed Commit

This block sits between a two-wire serial slave front end and a 256x8 non-volatile array. While a write command is in progress, the front end passes it the starting byte address and then each received data byte. Each byte comes with a per-byte permission bit from the protection logic. The engine keeps the bytes in a 16-entry row buffer, one entry per low address nibble. It marks the entries whose byte was allowed, so that each of those bytes is acknowledged on the bus.

When the bus master ends the command with a STOP in the slot right after an acknowledge, the engine starts a self-timed write cycle. For the whole cycle it raises busy. It sweeps the row buffer and writes each marked entry to its array location in the latched row. It then waits out the rest of a parameterised cycle length. While busy, the engine acknowledges nothing and changes no state, so a master polling with START and device select sees NoAck until the cycle ends. A STOP in any other slot, or a new START, throws the buffered bytes away.

Top module: `page_write_engine`

## Requirements
- R1: After reset, busy_o, mem_we_o and resp_vld_o are 0 and cur_addr_o is 0x00.
- R2: Each byte received while idle advances only the low 4 bits of cur_addr_o, so the upper 4 bits stay fixed and address xF wraps to x0 of the same row. A later byte for the same position replaces the earlier one in the buffer.
- R3: A write cycle starts only on stop_i with stop_slot_i equal to 10 while at least one buffer entry is marked. busy_o is then 1 from the next cycle for exactly WRITE_CYCLES cycles.
- R4: A stop_i with any other stop_slot_i value, or a start_i, clears the buffer. A STOP in slot 10 that follows it then starts no cycle and writes nothing.
- R5: A byte with byte_perm_i = 0 gets resp_ack_o = 0, and its array location is not written by the next cycle.
- R6: During a cycle, mem_we_o pulses once for each marked entry. mem_addr_o is {row, entry index}, where row is cur_addr_o[7:4], and mem_wdata_o is the last byte buffered for that entry. Unmarked entries are not written.
- R7: While busy_o is 1, byte_vld_i, addr_load_i, start_i and stop_i have no effect: cur_addr_o stays the same and no later array write carries those bytes.
- R8: Every dev_sel_i, addr_load_i or byte_vld_i pulse gives resp_vld_o = 1 on the next cycle. resp_ack_o is 1 only if busy_o was 0 and, for a data byte, byte_perm_i was 1.
- R9: When the cycle ends, the buffer is empty and cur_addr_o holds the address after the last byte received, wrapped within the row.
- R10: addr_load_i while idle loads cur_addr_o from addr_i and clears the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_load_i | input | 1 | Byte-address strobe from the front end |
| addr_i | input | 8 | Start byte address |
| dev_sel_i | input | 1 | Own device select received |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_data_i | input | 8 | Data byte |
| byte_perm_i | input | 1 | Protection allows writing the current address |
| start_i | input | 1 | START or repeated START seen on the bus |
| stop_i | input | 1 | STOP seen on the bus |
| stop_slot_i | input | 4 | Bit slot in which the STOP occurred (10 = right after ack) |
| resp_vld_o | output | 1 | Response for the previous strobe is valid |
| resp_ack_o | output | 1 | 1 = acknowledge, 0 = NoAck |
| busy_o | output | 1 | Self-timed write cycle in progress |
| cur_addr_o | output | 8 | Internal byte address counter |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 8 | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The bench sends pages that start near the end of a row and run past it by several bytes. A design that carried into the upper address bits would write into the next row, and one that failed to replace wrapped entries would write stale data. It ends commands with STOPs in the wrong slot and with a START before the STOP, either of which would start a cycle in a design that checks only for a STOP. It polls with device select, data bytes and address loads during busy; a design that let them through would acknowledge early, move the address counter or commit bytes it should have ignored. Denied bytes placed between allowed ones show whether an engine writes whole rows instead of marked entries only.

// File: rtl/pwe_pkg.sv
`timescale 1ns/1ps
package pwe_pkg;
  typedef enum logic [1:0] {
    TMR_IDLE   = 2'd0,
    TMR_SWEEP  = 2'd1,
    TMR_SETTLE = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/pwe_row_store.sv
`timescale 1ns/1ps
module pwe_row_store #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  localparam int IW        = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [IW-1:0]     wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IW-1:0]     rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_mark_o,
  output logic              any_mark_o
);
  logic [PAGE_BYTES-1:0] mark_q;
  logic [DATA_W-1:0]     data_q [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_entry
    logic hit;
    assign hit = wr_i && (wr_idx_i == IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mark_q[g] <= 1'b0;
        data_q[g] <= '0;
      end else if (clr_i) begin
        mark_q[g] <= 1'b0;
      end else if (hit) begin
        mark_q[g] <= 1'b1;
        data_q[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o  = data_q[rd_idx_i];
  assign rd_mark_o  = mark_q[rd_idx_i];
  assign any_mark_o = |mark_q;

  // R9: a clear empties the buffer on the next cycle
  a_r9_clr_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !any_mark_o);
endmodule

// File: rtl/pwe_cycle_timer.sv
`timescale 1ns/1ps
module pwe_cycle_timer
  import pwe_pkg::*;
#(
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 2000000,
  localparam int IW          = $clog2(PAGE_BYTES),
  localparam int CW          = $clog2(WRITE_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  output logic          busy_o,
  output logic          sweep_o,
  output logic [IW-1:0] idx_o,
  output logic          done_o
);
  tmr_state_e state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        TMR_IDLE: if (go_i) begin
          state_q <= TMR_SWEEP;
          cnt_q   <= '0;
        end
        TMR_SWEEP: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(PAGE_BYTES - 1)) state_q <= TMR_SETTLE;
        end
        TMR_SETTLE: begin
          if (cnt_q == CW'(WRITE_CYCLES - 1)) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: state_q <= TMR_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != TMR_IDLE);
  assign sweep_o = (state_q == TMR_SWEEP);
  assign idx_o   = cnt_q[IW-1:0];
  assign done_o  = (state_q == TMR_SETTLE) && (cnt_q == CW'(WRITE_CYCLES - 1));

  // R3: busy never drops before the full count
  a_r3_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  a_r3_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R6: every cycle begins with the buffer sweep
  a_r6_sweep_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> sweep_o && (idx_o == '0));
endmodule

// File: rtl/page_write_engine.sv
`timescale 1ns/1ps
module page_write_engine #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 16,
  parameter int SLOT_W       = 4,
  parameter int COMMIT_SLOT  = 10,
  parameter int WRITE_CYCLES = 2000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dev_sel_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              byte_perm_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [SLOT_W-1:0] stop_slot_i,
  output logic              resp_vld_o,
  output logic              resp_ack_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int IW = $clog2(PAGE_BYTES);
  localparam int RW = ADDR_W - IW;

  logic              busy, sweep, done;
  logic [IW-1:0]     sweep_idx;
  logic [ADDR_W-1:0] ptr_q;
  logic              take_byte, store_byte, commit, clr_buf, any_mark, rd_mark;
  logic [DATA_W-1:0] rd_data;

  assign take_byte  = byte_vld_i && !busy;
  assign store_byte = take_byte && byte_perm_i;
  assign commit     = stop_i && !busy && any_mark &&
                      (stop_slot_i == SLOT_W'(COMMIT_SLOT));
  assign clr_buf    = done ||
                      (!busy && (start_i || addr_load_i || (stop_i && !commit)));

  // address counter: only the in-row bits advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (!busy && addr_load_i) begin
      ptr_q <= addr_i;
    end else if (take_byte) begin
      ptr_q[IW-1:0] <= ptr_q[IW-1:0] + IW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_vld_o <= 1'b0;
      resp_ack_o <= 1'b0;
    end else begin
      resp_vld_o <= dev_sel_i || addr_load_i || byte_vld_i;
      resp_ack_o <= !busy && (byte_vld_i ? byte_perm_i : (dev_sel_i || addr_load_i));
    end
  end

  pwe_row_store #(
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_buf),
    .wr_i      (store_byte),
    .wr_idx_i  (ptr_q[IW-1:0]),
    .wr_data_i (byte_data_i),
    .rd_idx_i  (sweep_idx),
    .rd_data_o (rd_data),
    .rd_mark_o (rd_mark),
    .any_mark_o(any_mark)
  );

  pwe_cycle_timer #(
    .PAGE_BYTES  (PAGE_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (commit),
    .busy_o (busy),
    .sweep_o(sweep),
    .idx_o  (sweep_idx),
    .done_o (done)
  );

  assign busy_o      = busy;
  assign cur_addr_o  = ptr_q;
  assign mem_we_o    = sweep && rd_mark;
  assign mem_addr_o  = {ptr_q[ADDR_W-1:IW], sweep_idx};
  assign mem_wdata_o = rd_data;

  // R3: qualifying STOP starts the cycle
  a_r3_commit_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> busy_o);
  // R7: address counter frozen while busy
  a_r7_ptr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cur_addr_o));
  // R6: array writes only inside a cycle and inside the latched row
  a_r6_we_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o && (mem_addr_o[ADDR_W-1:IW] == cur_addr_o[ADDR_W-1:IW]));
  // R8: requests during busy are refused
  a_r8_nack_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_sel_i && busy_o) |=> resp_vld_o && !resp_ack_o);
  // R5: denied bytes are refused
  a_r5_denied_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !byte_perm_i) |=> !resp_ack_o);
  // R2: row bits do not move on a data byte
  a_r2_row_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !addr_load_i) |=> $stable(cur_addr_o[ADDR_W-1:IW]));
endmodule

// File: tb/page_write_engine_tb_top.sv
`timescale 1ns/1ps
module page_write_engine_tb_top;
  localparam int WC = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_load = 0, dev_sel = 0, byte_vld = 0, byte_perm = 0;
  logic       start_ev = 0, stop_ev = 0;
  logic [7:0] addr = 0, bdata = 0;
  logic [3:0] slot = 0;
  logic       resp_vld, resp_ack, busy, mem_we;
  logic [7:0] cur_addr, mem_addr, mem_wdata;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] obs_mem [256];
  logic [7:0] sh_data [16];
  bit         sh_mark [16];
  logic [7:0] sh_ptr;

  always #2.5 clk = ~clk;

  page_write_engine #(.WRITE_CYCLES(WC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_load_i(addr_load), .addr_i(addr),
    .dev_sel_i(dev_sel), .byte_vld_i(byte_vld), .byte_data_i(bdata),
    .byte_perm_i(byte_perm), .start_i(start_ev), .stop_i(stop_ev),
    .stop_slot_i(slot), .resp_vld_o(resp_vld), .resp_ack_o(resp_ack),
    .busy_o(busy), .cur_addr_o(cur_addr), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata));

  always @(negedge clk) if (rst_n && mem_we) obs_mem[mem_addr] = mem_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sh_clear();
    for (int i = 0; i < 16; i++) sh_mark[i] = 0;
  endtask

  task automatic mem_cmp(input string req);
    int diffs = 0;
    for (int i = 0; i < 256; i++) if (obs_mem[i] !== exp_mem[i]) diffs++;
    chk(diffs == 0, req, diffs, 0);
  endtask

  task automatic load_addr(input logic [7:0] a, input bit model);
    @(negedge clk); addr_load = 1; addr = a;
    @(negedge clk); addr_load = 0;
    if (model) begin sh_ptr = a; sh_clear(); end
  endtask

  task automatic send_byte(input logic [7:0] d, input bit perm, input bit exp_ack,
                           input bit model, input string req);
    @(negedge clk); byte_vld = 1; bdata = d; byte_perm = perm;
    @(negedge clk); byte_vld = 0;
    chk(resp_vld && (resp_ack == exp_ack), req, {resp_vld, resp_ack}, {1'b1, exp_ack});
    if (model) begin
      if (perm) begin sh_data[sh_ptr[3:0]] = d; sh_mark[sh_ptr[3:0]] = 1; end
      sh_ptr = {sh_ptr[7:4], sh_ptr[3:0] + 4'd1};
    end
  endtask

  task automatic pulse_stop(input logic [3:0] s);
    @(negedge clk); stop_ev = 1; slot = s;
    @(negedge clk); stop_ev = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_ev = 1;
    @(negedge clk); start_ev = 0;
  endtask

  task automatic poll(input bit exp_ack, input string req);
    @(negedge clk); dev_sel = 1;
    @(negedge clk); dev_sel = 0;
    chk(resp_vld && (resp_ack == exp_ack), req, {resp_vld, resp_ack}, {1'b1, exp_ack});
  endtask

  task automatic apply_shadow();
    for (int i = 0; i < 16; i++)
      if (sh_mark[i]) exp_mem[{sh_ptr[7:4], 4'(i)}] = sh_data[i];
    sh_clear();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < WC + 10) begin n++; @(negedge clk); end
  endtask

  task automatic commit_full(input string req);
    int n;
    pulse_stop(4'd10);
    apply_shadow();
    wait_idle(n);
    chk(n == WC, {req, " R3 busy length"}, n, WC);
    mem_cmp({req, " R6 array"});
    chk(cur_addr == sh_ptr, {req, " R9 addr after"}, cur_addr, sh_ptr);
  endtask

  task automatic t_reset();
    chk(!busy && !mem_we && !resp_vld, "R1 reset outputs", {busy, mem_we, resp_vld}, 0);
    chk(cur_addr == 8'h00, "R1 reset addr", cur_addr, 0);
  endtask

  task automatic t_byte_write();
    load_addr(8'h35, 1);
    chk(cur_addr == 8'h35, "R10 addr load", cur_addr, 8'h35);
    send_byte(8'hA7, 1, 1, 1, "R8 byte ack");
    chk(cur_addr == 8'h36, "R2 advance", cur_addr, 8'h36);
    commit_full("single");
  endtask

  task automatic t_page_wrap();
    load_addr(8'h4E, 1);
    for (int i = 0; i < 5; i++) send_byte(8'h10 + 8'(i), 1, 1, 1, "R2 page byte");
    chk(cur_addr == 8'h43, "R2 wrap in row", cur_addr, 8'h43);
    commit_full("wrap");
    load_addr(8'h7E, 1);
    for (int i = 0; i < 18; i++) send_byte(8'h80 + 8'(i), 1, 1, 1, "R2 overflow byte");
    commit_full("R2 overwrite");
  endtask

  task automatic t_denied();
    load_addr(8'h20, 1);
    send_byte(8'h11, 1, 1, 1, "R8 allowed");
    send_byte(8'h22, 0, 0, 1, "R5 denied nack");
    send_byte(8'h33, 1, 1, 1, "R8 allowed");
    commit_full("R5 denied");
  endtask

  task automatic t_bad_stop();
    int n;
    load_addr(8'h90, 1);
    send_byte(8'h5A, 1, 1, 1, "R8 byte");
    pulse_stop(4'd5);
    chk(!busy, "R4 wrong slot no cycle", busy, 0);
    sh_clear();
    pulse_stop(4'd10);
    chk(!busy, "R4 buffer discarded", busy, 0);
    load_addr(8'hA0, 1);
    send_byte(8'h6B, 1, 1, 1, "R8 byte");
    pulse_start();
    pulse_stop(4'd10);
    chk(!busy, "R4 start discards", busy, 0);
    load_addr(8'hB0, 1);
    pulse_stop(4'd10);
    chk(!busy, "R3 empty stop no cycle", busy, 0);
    wait_idle(n);
    mem_cmp("R4 no writes");
  endtask

  task automatic t_busy_poll();
    int n;
    logic [7:0] hold;
    load_addr(8'hC3, 1);
    send_byte(8'hE1, 1, 1, 1, "R8 byte");
    send_byte(8'hE2, 1, 1, 1, "R8 byte");
    pulse_stop(4'd10);
    apply_shadow();
    chk(busy, "R3 busy after stop", busy, 1);
    hold = cur_addr;
    poll(0, "R8 poll nack");
    send_byte(8'hFE, 1, 0, 0, "R7 byte nack busy");
    load_addr(8'h05, 0);
    pulse_start();
    pulse_stop(4'd3);
    chk(cur_addr == hold, "R7 addr frozen", cur_addr, hold);
    wait_idle(n);
    chk(!busy, "R3 cycle ends", busy, 0);
    chk(cur_addr == 8'hC5, "R9 addr after", cur_addr, 8'hC5);
    mem_cmp("R7 ignored bytes");
    poll(1, "R8 poll ack");
    send_byte(8'h77, 1, 1, 1, "R9 continues at counter");
    commit_full("R9 continue");
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin exp_mem[i] = 8'hFF; obs_mem[i] = 8'hFF; end
    sh_clear();
    sh_ptr = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_byte_write();
    t_page_wrap();
    t_denied();
    t_bad_stop();
    t_busy_poll();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule